// File: doc/BRIEF.md
# Sleep-Mode Power-Down Controller

This block sits beside a synchronous memory array and decides when the array may enter and leave a low-power sleep state. A sleep request arrives on a pin that is not tied to the clock. The block brings that request into the clock domain, then steps through a fixed entry window, the sleep state itself and a fixed recovery window before it accepts commands again.

While the block is not fully awake it masks the chip-select and address-strobe lines on their way to the array, so the array sees no commands. It also keeps the data-output drivers off. When entry starts, the block raises a one-cycle abort flag if an access was still in progress, because that access is dropped. It raises a one-cycle violation flag if the device was still selected at that moment, because the rules require the device to be deselected before sleep. The array's stored contents are left alone throughout.

Top module: `slpctl_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the awake state. After that edge `asleep_o`=0, `cmd_accept_o`=1, `abort_o`=0 and `viol_o`=0.
- R2: `sleep_req_i` passes through two flip-flops before the state logic uses it. If the request is first high at rising edge 0, `cmd_accept_o` stays 1 after edges 0 and 1 and drops to 0 after edge 2.
- R3: Entry lasts ENTRY_CYC cycles (default 2). `asleep_o` rises ENTRY_CYC edges after `cmd_accept_o` falls, which is after edge 4 of R2's count.
- R4: If the request is first seen low at edge 0 while asleep, `asleep_o` falls after edge 2 and recovery begins. `cmd_accept_o` returns to 1 EXIT_CYC edges later (default 2), which is after edge 4.
- R5: Whenever `cmd_accept_o` is 0, which covers entry, sleep and recovery, `sel_gated_o` and `strb_gated_o` are all zeros whatever the inputs are. When it is 1, they equal `chip_sel_i` and `addr_strb_i`.
- R6: `abort_o` is high for exactly the one cycle after the edge that starts entry, and only if `access_busy_i` was 1 at that edge. `access_busy_i` has no effect at any other time.
- R7: `viol_o` is high for exactly the one cycle after the edge that starts entry, and only if every bit of `chip_sel_i` was 1 at that edge.
- R8: `dq_oe_o` equals `drive_req_i` while awake and is 0 in every other state.
- R9: If the request is released during entry, entry still completes. `asleep_o` is then high for one cycle, and recovery follows at once.
- R10: A reset taken while asleep makes the block awake on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req_i | input | 1 | Sleep request, not tied to the clock |
| chip_sel_i | input | NSEL | Chip enables, active high. The device counts as selected when all bits are 1 |
| addr_strb_i | input | NSTB | Address strobes, active high |
| access_busy_i | input | 1 | The array has an access in progress |
| drive_req_i | input | 1 | The array wants to drive the data outputs |
| asleep_o | output | 1 | The array is in sleep |
| cmd_accept_o | output | 1 | Commands may pass to the array (awake only) |
| sel_gated_o | output | NSEL | Chip enables after masking |
| strb_gated_o | output | NSTB | Address strobes after masking |
| dq_oe_o | output | 1 | Data-output drive enable |
| abort_o | output | 1 | One-cycle pulse: an access in progress was dropped at entry |
| viol_o | output | 1 | One-cycle pulse: sleep was requested while the device was selected |

## Verification
Counting from the first edge that captures a change on the request pin, `cmd_accept_o` moves after the third edge and `asleep_o` moves after the fifth edge on entry and after the third edge on release. `abort_o` and `viol_o` are registered, so they are due one edge after entry begins. The masked selects, masked strobes and `dq_oe_o` follow the current inputs within the same cycle. The bench applies each vector on the falling edge and samples 1 ns after the next rising edge, so every expected value in the table is written for the state reached at that edge. A directed sequence then checks the reset state and a reset taken during sleep.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE      = 2'd0,
        ST_ENTERING   = 2'd1,
        ST_ASLEEP     = 2'd2,
        ST_RECOVERING = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic asleep;
        logic accept;
        logic abort;
        logic viol;
    } slp_flags_t;

    // counter width able to hold the larger window length
    function automatic int win_cnt_bits(input int entry_len, input int exit_len);
        int m;
        m = (entry_len > exit_len) ? entry_len : exit_len;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/slpctl_sync.sv
module slpctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
    import slpctl_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int CNT_W     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_sync_i,
    input  logic       selected_i,
    input  logic       busy_i,
    output slp_flags_t flags_o
);
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

    slp_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             abort_q;
    logic             viol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_AWAKE;
            cnt     <= '0;
            abort_q <= 1'b0;
            viol_q  <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            viol_q  <= 1'b0;
            case (state)
                ST_AWAKE: begin
                    if (req_sync_i) begin
                        state   <= ST_ENTERING;
                        cnt     <= '0;
                        abort_q <= busy_i;
                        viol_q  <= selected_i;
                    end
                end
                ST_ENTERING: begin
                    // entry runs to completion even if the request drops
                    if (cnt == ENTRY_LAST) begin
                        state <= ST_ASLEEP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ASLEEP: begin
                    if (!req_sync_i) begin
                        state <= ST_RECOVERING;
                        cnt   <= '0;
                    end
                end
                ST_RECOVERING: begin
                    if (cnt == EXIT_LAST) begin
                        state <= ST_AWAKE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_AWAKE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        flags_o.asleep = (state == ST_ASLEEP);
        flags_o.accept = (state == ST_AWAKE);
        flags_o.abort  = abort_q;
        flags_o.viol   = viol_q;
    end
endmodule

// File: rtl/slpctl_gate.sv
module slpctl_gate #(
    parameter int NSEL = 2,
    parameter int NSTB = 2
) (
    input  logic            accept_i,
    input  logic [NSEL-1:0] sel_i,
    input  logic [NSTB-1:0] strb_i,
    input  logic            drive_i,
    output logic [NSEL-1:0] sel_o,
    output logic [NSTB-1:0] strb_o,
    output logic            oe_o
);
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel_o[i] = sel_i[i] & accept_i;
    end
    for (genvar j = 0; j < NSTB; j++) begin : g_strb
        assign strb_o[j] = strb_i[j] & accept_i;
    end
    assign oe_o = drive_i & accept_i;
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
    import slpctl_pkg::*;
#(
    parameter int NSEL        = 2,
    parameter int NSTB        = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_req_i,
    input  logic [NSEL-1:0] chip_sel_i,
    input  logic [NSTB-1:0] addr_strb_i,
    input  logic            access_busy_i,
    input  logic            drive_req_i,
    output logic            asleep_o,
    output logic            cmd_accept_o,
    output logic [NSEL-1:0] sel_gated_o,
    output logic [NSTB-1:0] strb_gated_o,
    output logic            dq_oe_o,
    output logic            abort_o,
    output logic            viol_o
);
    localparam int CNT_W = win_cnt_bits(ENTRY_CYC, EXIT_CYC);

    logic       req_sync;
    slp_flags_t flags;

    slpctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sleep_req_i),
        .q_o (req_sync)
    );

    slpctl_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_sync_i (req_sync),
        .selected_i (&chip_sel_i),
        .busy_i     (access_busy_i),
        .flags_o    (flags)
    );

    slpctl_gate #(.NSEL(NSEL), .NSTB(NSTB)) u_gate (
        .accept_i (flags.accept),
        .sel_i    (chip_sel_i),
        .strb_i   (addr_strb_i),
        .drive_i  (drive_req_i),
        .sel_o    (sel_gated_o),
        .strb_o   (strb_gated_o),
        .oe_o     (dq_oe_o)
    );

    assign asleep_o     = flags.asleep;
    assign cmd_accept_o = flags.accept;
    assign abort_o      = flags.abort;
    assign viol_o       = flags.viol;
endmodule

// File: rtl/slpctl_checker.sv
module slpctl_checker #(
    parameter int NSEL = 2,
    parameter int NSTB = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            asleep_o,
    input logic            cmd_accept_o,
    input logic [NSEL-1:0] sel_gated_o,
    input logic [NSTB-1:0] strb_gated_o,
    input logic            dq_oe_o,
    input logic            abort_o,
    input logic            viol_o
);
    assert_reset_awake_R1: assert property (@(posedge clk)
        rst |=> (!asleep_o && cmd_accept_o && !abort_o && !viol_o));

    assert_entry_window_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep_o) |-> (!$past(cmd_accept_o, 1) && !$past(cmd_accept_o, 2)));

    assert_recover_first_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(asleep_o) && !$past(rst)) |-> !cmd_accept_o);

    assert_gate_closed_R5: assert property (@(posedge clk) disable iff (rst)
        !cmd_accept_o |-> (sel_gated_o == '0 && strb_gated_o == '0));

    assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    assert_abort_at_entry_R6: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> ($past(cmd_accept_o) && !cmd_accept_o));

    assert_viol_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        viol_o |=> !viol_o);

    assert_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_accept_o |-> !dq_oe_o);
endmodule

bind slpctl_top slpctl_checker #(.NSEL(NSEL), .NSTB(NSTB)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .asleep_o     (asleep_o),
    .cmd_accept_o (cmd_accept_o),
    .sel_gated_o  (sel_gated_o),
    .strb_gated_o (strb_gated_o),
    .dq_oe_o      (dq_oe_o),
    .abort_o      (abort_o),
    .viol_o       (viol_o)
);

// File: tb/slpctl_top_test.sv
module slpctl_top_test;
    localparam int NSEL = 2;
    localparam int NSTB = 2;
    localparam int NV   = 30;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sleep_req_i = 1'b0;
    logic [NSEL-1:0] chip_sel_i = '0;
    logic [NSTB-1:0] addr_strb_i = '0;
    logic            access_busy_i = 1'b0;
    logic            drive_req_i = 1'b0;
    logic            asleep_o, cmd_accept_o, dq_oe_o, abort_o, viol_o;
    logic [NSEL-1:0] sel_gated_o;
    logic [NSTB-1:0] strb_gated_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slpctl_top #(.NSEL(NSEL), .NSTB(NSTB)) uut (
        .clk (clk), .rst (rst), .sleep_req_i (sleep_req_i),
        .chip_sel_i (chip_sel_i), .addr_strb_i (addr_strb_i),
        .access_busy_i (access_busy_i), .drive_req_i (drive_req_i),
        .asleep_o (asleep_o), .cmd_accept_o (cmd_accept_o),
        .sel_gated_o (sel_gated_o), .strb_gated_o (strb_gated_o),
        .dq_oe_o (dq_oe_o), .abort_o (abort_o), .viol_o (viol_o)
    );

    // {req, sel, stb, busy, drv | asleep, accept, abort, viol, oe, gsel, gstb}
    // row k is applied on the falling edge before rising edge k and checked after it
    localparam logic [11:0] VEC [NV] = '{
        12'b01101_0100111, // 0 awake, pass-through (R5, R8)
        12'b00000_0100000, // 1
        12'b11111_0100111, // 2 request captured by first flop (R2)
        12'b11111_0100111, // 3 second flop (R2)
        12'b11111_0011000, // 4 entry starts: abort R6, violation R7
        12'b10001_0000000, // 5 entering
        12'b11101_1000000, // 6 asleep (R3)
        12'b10000_1000000, // 7
        12'b00000_1000000, // 8 release captured
        12'b01101_1000000, // 9
        12'b01111_0000000, // 10 recovering, commands and busy ignored (R4, R5)
        12'b01101_0000000, // 11
        12'b01101_0100111, // 12 awake again (R4)
        12'b10000_0100000, // 13
        12'b10000_0100000, // 14
        12'b10000_0000000, // 15 entering, no abort or violation
        12'b00000_0000000, // 16 released during entry (R9)
        12'b00000_1000000, // 17 asleep for one cycle (R9)
        12'b01101_0000000, // 18 recovering
        12'b01101_0000000, // 19
        12'b00100_0100001, // 20 awake
        12'b01001_0100110, // 21
        12'b10010_0100000, // 22
        12'b10010_0100000, // 23
        12'b10010_0010000, // 24 abort without violation (R6, R7)
        12'b00000_0000000, // 25
        12'b00000_1000000, // 26
        12'b00000_0000000, // 27
        12'b00000_0000000, // 28
        12'b00000_0100000  // 29
    };

    task automatic chk(input string tag, input int row, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s row %0d: actual %0h expected %0h", tag, row, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] stim);
        sleep_req_i   = stim[4];
        chip_sel_i    = {NSEL{stim[3]}};
        addr_strb_i   = {NSTB{stim[2]}};
        access_busy_i = stim[1];
        drive_req_i   = stim[0];
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 asleep", -1, {7'd0, asleep_o}, 8'd0);
        chk("R1 accept", -1, {7'd0, cmd_accept_o}, 8'd1);
        chk("R1 abort",  -1, {7'd0, abort_o}, 8'd0);
        chk("R1 viol",   -1, {7'd0, viol_o}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i][11:7]);
            @(posedge clk);
            #1;
            chk("R3 asleep", i, {7'd0, asleep_o},     {7'd0, VEC[i][6]});
            chk("R2 accept", i, {7'd0, cmd_accept_o}, {7'd0, VEC[i][5]});
            chk("R6 abort",  i, {7'd0, abort_o},      {7'd0, VEC[i][4]});
            chk("R7 viol",   i, {7'd0, viol_o},       {7'd0, VEC[i][3]});
            chk("R8 oe",     i, {7'd0, dq_oe_o},      {7'd0, VEC[i][2]});
            chk("R5 sel",    i, 8'(sel_gated_o),  8'({NSEL{VEC[i][1]}}));
            chk("R5 strb",   i, 8'(strb_gated_o), 8'({NSTB{VEC[i][0]}}));
        end

        // R10: reset during sleep
        @(negedge clk);
        apply(5'b10000);
        repeat (5) @(posedge clk);
        #1;
        chk("R10 asleep before reset", 100, {7'd0, asleep_o}, 8'd1);
        @(negedge clk);
        rst = 1'b1;
        apply(5'b00000);
        @(posedge clk);
        #1;
        chk("R10 asleep", 101, {7'd0, asleep_o}, 8'd0);
        chk("R10 accept", 101, {7'd0, cmd_accept_o}, 8'd1);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R1: stays awake with no request after reset
        chk("R1 accept after idle", 102, {7'd0, cmd_accept_o}, 8'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule